// File: doc/BRIEF.md
# Dual-Clock FIFO with Read-Domain Empty Flag and Sub-Word Reads

This block is a first-in first-out buffer that moves 36-bit words from a write clock domain to an unrelated read clock domain. The storage array holds 64 words. The read side owns a 36-bit output register that is filled automatically. When a word reaches an empty buffer, it is loaded into that register on the same read-clock edge that raises the active-low empty flag, so no separate read is needed to present it. The write and read positions are kept as 7-bit Gray-coded pointers. Each pointer crosses into the other domain through a two-flop synchronizer, so the empty flag changes only on read-clock edges and the full flag changes only on write-clock edges.

The write port works as a stream. A word is accepted on a write-clock edge when `wr_valid` is high and `wr_full` is low. While `wr_full` is high, `wr_valid` is ignored, so the producer must hold its word and wait. On the read port, `rd_empty_n` acts as the valid signal for `rd_data` and `rd_ready` is the consumer's request.

A separate bus-matching stage can read each long word as two halves or four bytes. It reports the transfer size on `rd_size` and marks the final piece of each long word with `rd_last_sub`. Only a final beat retires the word held in the output register. Earlier beats leave both the data and the flag untouched. As a result, the empty flag falls only after the last piece of the last word has been read.

Top module: `fifo_bm_efsync`

## Requirements
- R1: During and right after reset, `rd_empty_n` is 0 and `wr_full` is 0.
- R2: A word is stored on a `wclk` edge exactly when `wr_valid`=1 and `wr_full`=0. A `wr_valid` while `wr_full`=1 stores nothing and does not overwrite any stored word.
- R3: With the reader idle, exactly 65 words are accepted: 64 in the array and 1 in the output register. After that, `wr_full` stays 1.
- R4: The first word written into an empty FIFO is on `rd_data` at the `rclk` edge where `rd_empty_n` rises, and no read is needed for this.
- R5: After a word is accepted into an empty FIFO, `rd_empty_n` rises on the third `rclk` edge after the accepting `wclk` edge. If the write edge does not lead the read edge by enough margin, it rises on the fourth edge instead. The delay therefore lies between 2 and 4 read periods.
- R6: `rd_size` encoding: 2'b00 selects a long word (36 bits), 2'b01 a half word, 2'b10 a byte, and 2'b11 is treated as a sub-word size. A read with a sub-word size and `rd_last_sub`=0 leaves both `rd_data` and `rd_empty_n` unchanged.
- R7: A final beat retires the word in the output register. A final beat is `rd_ready`=1 and `rd_empty_n`=1, together with either `rd_size`=2'b00 or `rd_last_sub`=1. On the next `rclk` edge, either the next stored word is loaded or `rd_empty_n` falls to 0. `rd_empty_n` never falls without a final beat.
- R8: A read request while `rd_empty_n`=0 has no effect: the flag stays 0 and no stored word is skipped.
- R9: Words leave in the order they were accepted, with none lost and none duplicated.
- R10: Each Gray pointer changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_data | input | 36 | Word to store |
| wr_full | output | 1 | Storage full; also the inverse of write ready |
| rd_ready | input | 1 | Consumer takes a beat of the presented word |
| rd_size | input | 2 | Transfer size of the current beat (see R6) |
| rd_last_sub | input | 1 | This sub-word beat is the last piece of the long word |
| rd_data | output | 36 | Output register holding the oldest word |
| rd_empty_n | output | 1 | Active-low empty flag; high means `rd_data` is valid |

## Verification
The assertions check several properties on every clock cycle. In the write domain, a full buffer never takes a write. Each Gray pointer changes by at most one bit per cycle. A non-final sub-word beat keeps the presented word and the flag steady. The empty flag only falls after a final beat. Other behaviour can only be shown by the bench scenarios run with two unrelated clocks: the two-to-four read-period latency of the flag, the word on the output register when the flag rises, the exact capacity of 65 words, and end-to-end ordering under back-pressure at both ends.

// File: rtl/fifo_bm_pkg.sv
`timescale 1ns/1ps
package fifo_bm_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  function automatic logic [6:0] to_gray7(input logic [6:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/fifo_bm_gray_ptr.sv
`timescale 1ns/1ps
module fifo_bm_gray_ptr #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [PW-2:0] addr,
  output logic [PW-1:0] gray
);
  logic [PW-1:0] bin_q;
  logic [PW-1:0] bin_nx;

  assign bin_nx = bin_q + PW'(inc);
  assign addr   = bin_q[PW-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      gray  <= '0;
    end else begin
      bin_q <= bin_nx;
      gray  <= bin_nx ^ (bin_nx >> 1);
    end
  end

  // R10: one bit at a time so the far domain never samples a torn value
  assert_gray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray ^ $past(gray)) <= 1);
endmodule

// File: rtl/fifo_bm_sync.sv
`timescale 1ns/1ps
module fifo_bm_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_bm_ram.sv
`timescale 1ns/1ps
module fifo_bm_ram #(
  parameter int W  = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_bm_efsync.sv
`timescale 1ns/1ps
module fifo_bm_efsync #(
  parameter int W      = 36,
  parameter int AW     = 6,
  parameter int STAGES = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_full,
  input  logic         rd_ready,
  input  logic [1:0]   rd_size,
  input  logic         rd_last_sub,
  output logic [W-1:0] rd_data,
  output logic         rd_empty_n
);
  import fifo_bm_pkg::*;
  localparam int PW = AW + 1;

  // ---------------- write domain ----------------
  logic          w_acc;
  logic [AW-1:0] w_addr;
  logic [PW-1:0] w_gray, r_gray_in_w;

  assign w_acc   = wr_valid && !wr_full;
  assign wr_full = (w_gray == {~r_gray_in_w[PW-1:PW-2], r_gray_in_w[PW-3:0]});

  fifo_bm_gray_ptr #(.PW(PW)) u_wptr (
    .clk(wclk), .rst_n(rst_n), .inc(w_acc), .addr(w_addr), .gray(w_gray));

  fifo_bm_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(r_gray), .q(r_gray_in_w));

  // ---------------- storage ----------------
  logic [AW-1:0] r_addr;
  logic [W-1:0]  ram_q;

  fifo_bm_ram #(.W(W), .AW(AW)) u_ram (
    .wclk(wclk), .we(w_acc), .waddr(w_addr), .wdata(wr_data),
    .raddr(r_addr), .rdata(ram_q));

  // ---------------- read domain ----------------
  logic [PW-1:0] r_gray, w_gray_in_r;
  logic          final_beat, retire, mem_has, load;

  fifo_bm_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(w_gray), .q(w_gray_in_r));

  assign final_beat = (xfer_size_e'(rd_size) == SZ_LONG) || rd_last_sub;
  assign retire     = rd_ready && rd_empty_n && final_beat;
  assign mem_has    = (r_gray != w_gray_in_r);
  assign load       = mem_has && (!rd_empty_n || retire);

  fifo_bm_gray_ptr #(.PW(PW)) u_rptr (
    .clk(rclk), .rst_n(rst_n), .inc(load), .addr(r_addr), .gray(r_gray));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rd_empty_n <= 1'b0;
    end else if (load) begin
      rd_data    <= ram_q;
      rd_empty_n <= 1'b1;
    end else if (retire) begin
      rd_empty_n <= 1'b0;
    end
  end

  // R2: a full buffer never advances the write pointer
  assert_no_overflow_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_full |=> $stable(w_gray));

  // R6: a non-final sub-word beat leaves the presented word in place
  assert_subword_hold_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_empty_n && rd_ready && (rd_size != 2'b00) && !rd_last_sub)
      |=> (rd_empty_n && $stable(rd_data)));

  // R7: the flag only drops after a final beat
  assert_empty_fall_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(rd_empty_n) |-> $past(rd_ready && ((rd_size == 2'b00) || rd_last_sub)));

  // R8: an empty read side with nothing arriving stays empty
  assert_empty_read_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_empty_n && !mem_has) |=> !rd_empty_n);
endmodule

// File: tb/fifo_bm_efsync_tb.sv
`timescale 1ns/1ps
module fifo_bm_efsync_tb;
  localparam real TW = 5.0;
  localparam real TR = 7.3;

  logic        wclk = 0, rclk = 0, rst_n = 0;
  logic        wr_valid = 0, rd_ready = 0, rd_last_sub = 0;
  logic [35:0] wr_data = '0;
  logic [1:0]  rd_size = 2'b00;
  logic        wr_full, rd_empty_n;
  logic [35:0] rd_data;

  int checks = 0, errors = 0, seq = 1;
  logic [35:0] exp_q [$];

  always #(TW/2) wclk = ~wclk;
  initial begin #1.1; forever #(TR/2) rclk = ~rclk; end

  fifo_bm_efsync u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(wr_full), .rd_ready(rd_ready), .rd_size(rd_size), .rd_last_sub(rd_last_sub),
    .rd_data(rd_data), .rd_empty_n(rd_empty_n));

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor: compares every beat, pops on a final beat (R9)
  always @(negedge rclk) begin
    if (rst_n && rd_ready && rd_empty_n) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected word", rd_data, '0);
      else begin
        check(rd_data == exp_q[0], "R9 order", rd_data, exp_q[0]);
        if (rd_size == 2'b00 || rd_last_sub) void'(exp_q.pop_front());
      end
    end
  end

  task automatic write_words(input int attempts, input int gap, output int acc);
    acc = 0;
    @(posedge wclk); #1;
    for (int i = 0; i < attempts; i++) begin
      wr_valid = (gap == 0) || (i % gap != 0);
      wr_data  = {4'h5, 32'(seq)};
      @(negedge wclk);
      if (wr_valid && !wr_full) begin
        exp_q.push_back(wr_data); acc++; seq++;
      end
      @(posedge wclk); #1;
    end
    wr_valid = 0;
  endtask

  task automatic read_words(input int nwords, input logic [1:0] size, input int gap);
    int nb, beat, done, cyc;
    nb = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
    beat = 0; done = 0; cyc = 0;
    while (done < nwords) begin
      @(posedge rclk); #1;
      rd_ready = (gap == 0) || (cyc % gap != 0); cyc++;
      rd_size = size; rd_last_sub = (beat == nb - 1);
      @(negedge rclk);
      if (rd_ready && rd_empty_n) begin
        if (beat == nb - 1) begin beat = 0; done++; end
        else beat++;
      end
    end
    @(posedge rclk); #1;
    rd_ready = 0; rd_last_sub = 0;
  endtask

  initial begin
    repeat (1000000) @(posedge wclk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int acc;
    realtime t0, dt;
    logic [35:0] w;

    // R1: reset values
    repeat (3) @(posedge rclk);
    #1;
    check(rd_empty_n == 0, "R1 empty flag in reset", 36'(rd_empty_n), 0);
    check(wr_full == 0, "R1 full flag in reset", 36'(wr_full), 0);
    rst_n = 1;
    repeat (3) @(posedge rclk);
    #1;
    check(rd_empty_n == 0, "R1 empty flag after reset", 36'(rd_empty_n), 0);

    // R8: reads on an empty FIFO are ignored
    rd_ready = 1; rd_size = 2'b00;
    for (int i = 0; i < 6; i++) begin
      @(negedge rclk);
      if (i == 5) check(rd_empty_n == 0, "R8 empty read ignored", 36'(rd_empty_n), 0);
    end
    @(posedge rclk); #1 rd_ready = 0;

    // R4 / R5: first word latency and presentation
    @(posedge wclk); #1;
    wr_valid = 1; w = {4'h9, 32'(seq)}; wr_data = w;
    @(posedge wclk); t0 = $realtime; #1 wr_valid = 0;
    exp_q.push_back(w); seq++;
    @(posedge rd_empty_n); dt = $realtime - t0; #0.1;
    check((dt >= 2.0*TR - 0.01) && (dt <= 4.0*TR + 0.01), "R5 flag latency",
          36'($rtoi(dt*100.0)), 36'($rtoi(3.0*TR*100.0)));
    check(rd_data == w, "R4 first word presented", rd_data, w);
    check(rd_empty_n == 1, "R8 skipped no word", 36'(rd_empty_n), 1);
    read_words(1, 2'b00, 0);
    repeat (4) @(negedge rclk);
    check(rd_empty_n == 0, "R7 flag falls after long read", 36'(rd_empty_n), 0);

    // R6 / R7: byte reads, last piece retires the word
    write_words(1, 0, acc);
    wait (rd_empty_n == 1);
    @(posedge rclk); #1;
    w = exp_q[0];
    rd_ready = 1; rd_size = 2'b10; rd_last_sub = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge rclk);
      check(rd_empty_n == 1 && rd_data == w, "R6 non-final byte holds word", rd_data, w);
    end
    @(posedge rclk); #1 rd_last_sub = 1;
    @(posedge rclk); #1 rd_ready = 0; rd_last_sub = 0;
    @(negedge rclk);
    check(rd_empty_n == 0, "R7 last byte empties", 36'(rd_empty_n), 0);

    // R9: concurrent streams with back-pressure, three read sizes
    fork
      write_words(40, 3, acc);
      read_words(26, 2'b00, 3);
    join
    check(acc == 26, "R2 accepted count stream 1", 36'(acc), 26);
    fork
      write_words(30, 4, acc);
      read_words(22, 2'b01, 4);
    join
    fork
      write_words(12, 0, acc);
      read_words(12, 2'b11, 2);
    join
    repeat (6) @(negedge rclk);
    check(exp_q.size() == 0, "R9 all words delivered", 36'(exp_q.size()), 0);
    check(rd_empty_n == 0, "R7 empty after streams", 36'(rd_empty_n), 0);

    // R3 / R2: capacity with reader idle, extra writes ignored
    write_words(150, 0, acc);
    check(acc == 65, "R3 capacity", 36'(acc), 65);
    @(negedge wclk);
    check(wr_full == 1, "R3 full flag", 36'(wr_full), 1);
    read_words(65, 2'b00, 0);
    repeat (8) @(negedge rclk);
    check(exp_q.size() == 0, "R2 no overwrite while full", 36'(exp_q.size()), 0);
    check(rd_empty_n == 0, "R7 empty after drain", 36'(rd_empty_n), 0);
    check(wr_full == 0, "R3 full clears after drain", 36'(wr_full), 0);

    finish_run();
  end
endmodule